// File: doc/BRIEF.md
# Host Bridge Register Window Decoder

This block decodes a 16 MB register window that a CPU sees on the host side of a bus host bridge. Each access carries an address inside the window, a direction, a byte count of 1 to 4 and, for writes, data. Byte 0 of the data always sits in bits 7:0, and further bytes follow in little-endian order. The lower 12 MB of the window goes to an I/O space port. A small set of fixed offsets in the upper part reaches three things. The first is a latched configuration-address register. The second is a four-byte configuration-data port, whose accesses go to an external configuration-space responder together with the latched address and the byte offset within the port. The third is an interrupt-acknowledge read, which pulses a strobe to an interrupt controller and returns its vector. Every other offset answers with a default value and sets a sticky error flag.

The CPU side uses valid/ready on both the request and the response. `req_ready` is high only while no access is in flight, so at most one access is outstanding. A raised `rsp_valid` stays high with stable data until `rsp_ready` is seen, and the CPU may hold off `rsp_ready` for any number of cycles. Each downstream port uses valid/ready on its request: the request stays asserted with stable fields until its ready is sampled high. It then answers with a single-cycle response-valid pulse in a later cycle, and it may take any number of cycles to do so. The error flag and its clear input are plain pins.

Top module: `hbr_window`

## Requirements
- R1: A request with address below 0xC00000 is forwarded on the I/O port with the same address, direction, size code and write data. A read returns the data from the I/O response.
- R2: Offset 0xC00CF8 (exact match only) holds the 32-bit configuration address, which resets to 0. A write with size code s replaces bytes 0..s of the register with the matching bytes of the write data, and a read returns the register.
- R3: Offsets 0xE00CFC to 0xE00CFF, with bit 31 of the configuration address set, are forwarded on the configuration port with the latched address, offset = address bits 1:0, direction, size code and write data. A read returns the data from the configuration response.
- R4: A configuration-data access made while bit 31 of the configuration address is clear is not forwarded: a read returns all ones, a write is dropped, and the error flag is not touched.
- R5: A read of offset 0xF00000 raises `iack_strobe` for exactly one cycle, in the cycle the request is accepted, and returns the vector zero-extended to 32 bits.
- R6: A write to offset 0xF00000 raises no strobe and is handled as an unimplemented access.
- R7: Any other offset at or above 0xC00000 is unimplemented. A read returns all ones and a write is dropped. The access sets the sticky `err_flag`, and `err_clear` clears the flag. When both happen in the same cycle, the set wins.
- R8: The size code s (0..3) means s+1 bytes. Read data is masked to bits 8(s+1)-1:0, so all higher bits are zero. Every write response carries data 0.
- R9: `req_ready` is high only while idle, and no request is taken while a response is pending. `rsp_valid` and `rsp_rdata` hold until `rsp_ready` is high. A downstream request holds its valid and fields until its ready is high.
- R10: After reset, `req_ready` is 1, and `rsp_valid`, both downstream valids, `iack_strobe` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Decoder can take a request |
| req_addr | input | 24 | Offset inside the window |
| req_write | input | 1 | 1 for a write |
| req_size | input | 2 | Byte count minus one |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | CPU takes the response |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| io_valid | output | 1 | I/O space request valid |
| io_ready | input | 1 | I/O space takes the request |
| io_addr | output | 24 | I/O space address |
| io_write | output | 1 | I/O space direction |
| io_size | output | 2 | I/O space size code |
| io_wdata | output | 32 | I/O space write data |
| io_rsp_valid | input | 1 | I/O space response pulse |
| io_rsp_rdata | input | 32 | I/O space read data |
| cfg_valid | output | 1 | Configuration request valid |
| cfg_ready | input | 1 | Configuration side takes the request |
| cfg_reg | output | 32 | Latched configuration address |
| cfg_ofs | output | 2 | Byte offset within the data port |
| cfg_write | output | 1 | Configuration direction |
| cfg_size | output | 2 | Configuration size code |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rsp_valid | input | 1 | Configuration response pulse |
| cfg_rsp_rdata | input | 32 | Configuration read data |
| iack_strobe | output | 1 | Interrupt-acknowledge pulse |
| iack_vector | input | 8 | Vector from the interrupt controller |
| err_flag | output | 1 | Sticky unimplemented-access flag |
| err_clear | input | 1 | Clears the error flag |

## Verification
The bench builds the block with its default parameters: a 24-bit window, the I/O limit at 0xC00000, the three fixed offsets listed above and an 8-bit vector. With these values the exact edges of the decode can be driven, such as 0xBFFFFF against 0xC00000 and 0xC00CF8 against 0xC00CF9, along with every byte offset of the data port and every size code. Random traffic switches the enable bit of the configuration address on and off and applies random back-pressure on the CPU response and on both downstream ports. It also applies the clear input in the same cycle as an error, so that the priority of set over clear is tested.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = 8 * BUS_BYTES;

  typedef enum logic [2:0] {
    T_IO,
    T_CADDR,
    T_CDATA,
    T_IACK,
    T_NONE
  } tgt_e;

  function automatic logic [BUS_W-1:0] lane_mask(input logic [1:0] sz);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int b = 0; b < BUS_BYTES; b++) begin
      if (b <= int'(sz)) m[8*b +: 8] = 8'hFF;
    end
    return m;
  endfunction
endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
  import hbr_pkg::*;
#(
  parameter int AW = 24,
  parameter logic [AW-1:0] IO_LIMIT  = 24'hC0_0000,
  parameter logic [AW-1:0] CADDR_OFS = 24'hC0_0CF8,
  parameter logic [AW-1:0] CDATA_OFS = 24'hE0_0CFC,
  parameter logic [AW-1:0] IACK_OFS  = 24'hF0_0000
) (
  input  logic [AW-1:0] addr,
  input  logic          write,
  output tgt_e          tgt
);
  always_comb begin
    if (addr < IO_LIMIT)                        tgt = T_IO;
    else if (addr == CADDR_OFS)                 tgt = T_CADDR;
    else if (addr[AW-1:2] == CDATA_OFS[AW-1:2]) tgt = T_CDATA;
    else if ((addr == IACK_OFS) && !write)      tgt = T_IACK;
    else                                        tgt = T_NONE;
  end
endmodule

// File: rtl/hbr_cfg_addr.sv
module hbr_cfg_addr
  import hbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       size,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] q
);
  for (genvar b = 0; b < BUS_BYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       q[8*b +: 8] <= '0;
      else if (wr_en && (2'(b) <= size)) q[8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  AST_CADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q)); // R2
endmodule

// File: rtl/hbr_err_flag.sv
module hbr_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q); // R7
  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q); // R7
endmodule

// File: rtl/hbr_window.sv
module hbr_window
  import hbr_pkg::*;
#(
  parameter int AW    = 24,
  parameter int VEC_W = 8,
  parameter logic [AW-1:0] IO_LIMIT  = 24'hC0_0000,
  parameter logic [AW-1:0] CADDR_OFS = 24'hC0_0CF8,
  parameter logic [AW-1:0] CDATA_OFS = 24'hE0_0CFC,
  parameter logic [AW-1:0] IACK_OFS  = 24'hF0_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_rdata,
  output logic             io_valid,
  input  logic             io_ready,
  output logic [AW-1:0]    io_addr,
  output logic             io_write,
  output logic [1:0]       io_size,
  output logic [31:0]      io_wdata,
  input  logic             io_rsp_valid,
  input  logic [31:0]      io_rsp_rdata,
  output logic             cfg_valid,
  input  logic             cfg_ready,
  output logic [31:0]      cfg_reg,
  output logic [1:0]       cfg_ofs,
  output logic             cfg_write,
  output logic [1:0]       cfg_size,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_rsp_valid,
  input  logic [31:0]      cfg_rsp_rdata,
  output logic             iack_strobe,
  input  logic [VEC_W-1:0] iack_vector,
  input  logic             err_clear,
  output logic             err_flag
);
  typedef enum logic [1:0] {S_IDLE, S_FWD, S_WAIT, S_RESP} st_e;

  st_e              st;
  tgt_e             tgt;
  logic             accept, go_fwd, fwd_io;
  logic [AW-1:0]    l_addr;
  logic             l_write;
  logic [1:0]       l_size;
  logic [BUS_W-1:0] l_wdata, rdata_q, loc_rdata, caddr_q;
  logic             dn_ready, dn_rsp_valid;
  logic [BUS_W-1:0] dn_rdata;

  hbr_decode #(
    .AW(AW), .IO_LIMIT(IO_LIMIT), .CADDR_OFS(CADDR_OFS),
    .CDATA_OFS(CDATA_OFS), .IACK_OFS(IACK_OFS)
  ) u_dec (
    .addr(req_addr), .write(req_write), .tgt(tgt)
  );

  assign accept = req_valid && (st == S_IDLE);

  hbr_cfg_addr u_caddr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept && (tgt == T_CADDR) && req_write),
    .size(req_size), .wdata(req_wdata), .q(caddr_q)
  );

  hbr_err_flag u_err (
    .clk(clk), .rst_n(rst_n),
    .set(accept && (tgt == T_NONE)), .clr(err_clear), .q(err_flag)
  );

  assign go_fwd = (tgt == T_IO) || ((tgt == T_CDATA) && caddr_q[31]);

  always_comb begin
    unique case (tgt)
      T_CADDR: loc_rdata = caddr_q;
      T_IACK:  loc_rdata = {{(BUS_W-VEC_W){1'b0}}, iack_vector};
      default: loc_rdata = '1;
    endcase
    if (req_write) loc_rdata = '0;
    else           loc_rdata = loc_rdata & lane_mask(req_size);
  end

  assign dn_ready     = fwd_io ? io_ready     : cfg_ready;
  assign dn_rsp_valid = fwd_io ? io_rsp_valid : cfg_rsp_valid;
  assign dn_rdata     = fwd_io ? io_rsp_rdata : cfg_rsp_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      fwd_io  <= 1'b0;
      l_addr  <= '0;
      l_write <= 1'b0;
      l_size  <= '0;
      l_wdata <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          l_addr  <= req_addr;
          l_write <= req_write;
          l_size  <= req_size;
          l_wdata <= req_wdata;
          fwd_io  <= (tgt == T_IO);
          rdata_q <= loc_rdata;
          st      <= go_fwd ? S_FWD : S_RESP;
        end
        S_FWD: if (dn_ready) st <= S_WAIT;
        S_WAIT: if (dn_rsp_valid) begin
          rdata_q <= l_write ? '0 : (dn_rdata & lane_mask(l_size));
          st      <= S_RESP;
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == S_IDLE);
  assign rsp_valid   = (st == S_RESP);
  assign rsp_rdata   = rdata_q;
  assign iack_strobe = accept && (tgt == T_IACK);

  assign io_valid  = (st == S_FWD) && fwd_io;
  assign io_addr   = l_addr;
  assign io_write  = l_write;
  assign io_size   = l_size;
  assign io_wdata  = l_wdata;

  assign cfg_valid = (st == S_FWD) && !fwd_io;
  assign cfg_reg   = caddr_q;
  assign cfg_ofs   = l_addr[1:0];
  assign cfg_write = l_write;
  assign cfg_size  = l_size;
  assign cfg_wdata = l_wdata;

  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R9
  AST_IO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_ready) |=> (io_valid && $stable(io_addr))); // R9
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9
  AST_CFG_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> cfg_reg[31]); // R4
  AST_IACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    iack_strobe |=> !iack_strobe); // R5
endmodule

// File: tb/hbr_window_test.sv
`timescale 1ns/1ps
module hbr_window_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        io_valid, io_write;
  logic        io_ready = 1'b0, io_rsp_valid = 1'b0;
  logic [23:0] io_addr;
  logic [1:0]  io_size;
  logic [31:0] io_wdata;
  logic [31:0] io_rsp_rdata = '0;
  logic        cfg_valid, cfg_write;
  logic        cfg_ready = 1'b0, cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_reg, cfg_wdata;
  logic [1:0]  cfg_ofs, cfg_size;
  logic [31:0] cfg_rsp_rdata = '0;
  logic        iack_strobe, err_flag;
  logic [7:0]  iack_vector = '0;
  logic        err_clear = 1'b0;

  int errs = 0, checks = 0, strobes = 0;
  logic [31:0] caddr_m = '0;
  bit          err_m = 1'b0;

  always #4 clk = ~clk;

  hbr_window uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .io_valid(io_valid), .io_ready(io_ready), .io_addr(io_addr),
    .io_write(io_write), .io_size(io_size), .io_wdata(io_wdata),
    .io_rsp_valid(io_rsp_valid), .io_rsp_rdata(io_rsp_rdata),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_reg(cfg_reg),
    .cfg_ofs(cfg_ofs), .cfg_write(cfg_write), .cfg_size(cfg_size),
    .cfg_wdata(cfg_wdata), .cfg_rsp_valid(cfg_rsp_valid),
    .cfg_rsp_rdata(cfg_rsp_rdata), .iack_strobe(iack_strobe),
    .iack_vector(iack_vector), .err_clear(err_clear), .err_flag(err_flag)
  );

  always @(posedge clk) if (iack_strobe) strobes++;

  function automatic logic [31:0] bmask(input logic [1:0] sz);
    logic [31:0] m = '0;
    for (int b = 0; b <= int'(sz); b++) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  // 0 io, 1 config address, 2 config data, 3 iack read, 4 unimplemented
  function automatic int classify(input logic [23:0] a, input bit w);
    if (a < 24'hC00000) return 0;
    if (a == 24'hC00CF8) return 1;
    if (a >= 24'hE00CFC && a <= 24'hE00CFF) return 2;
    if (a == 24'hF00000 && !w) return 3;
    return 4;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [23:0] a, input bit w, input logic [1:0] sz,
                     input logic [31:0] wd, input bit clr);
    int cls, s0, k;
    bit fio, fcfg;
    string tg;
    logic [31:0] exp, got, dn;
    logic [7:0] vec;
    cls  = classify(a, w);
    fio  = (cls == 0);
    fcfg = (cls == 2) && caddr_m[31];
    case (cls)
      0: tg = "R1";
      1: tg = "R2";
      2: tg = fcfg ? "R3" : "R4";
      3: tg = "R5";
      default: tg = (a == 24'hF00000) ? "R6" : "R7";
    endcase
    vec = 8'($urandom);
    @(negedge clk);
    chk("R9 ready when idle", {31'b0, req_ready}, 32'd1);
    iack_vector = vec;
    req_addr = a; req_write = w; req_size = sz; req_wdata = wd;
    req_valid = 1'b1; err_clear = clr;
    s0 = strobes;
    @(negedge clk);
    req_valid = 1'b0; err_clear = 1'b0;
    if (a == 24'hF00000) chk(tg, 32'(strobes - s0), (cls == 3) ? 32'd1 : 32'd0);
    exp = '1;
    if (fio) begin
      chk({tg, " io req"}, {31'b0, io_valid}, 32'd1);
      chk({tg, " io addr"}, {8'b0, io_addr}, {8'b0, a});
      chk({tg, " io ctl"}, {29'b0, io_write, io_size}, {29'b0, w, sz});
      if (w) chk({tg, " io wdata"}, io_wdata, wd);
      k = $urandom % 3;
      repeat (k) begin
        @(negedge clk);
        chk("R9 io hold", {7'b0, io_valid, io_addr}, {7'b0, 1'b1, a});
      end
      io_ready = 1'b1;
      @(negedge clk);
      io_ready = 1'b0; dn = $urandom; io_rsp_valid = 1'b1; io_rsp_rdata = dn;
      @(negedge clk);
      io_rsp_valid = 1'b0;
      exp = w ? 32'h0 : (dn & bmask(sz));
    end else if (fcfg) begin
      chk({tg, " cfg req"}, {31'b0, cfg_valid}, 32'd1);
      chk({tg, " cfg reg"}, cfg_reg, caddr_m);
      chk({tg, " cfg ctl"}, {27'b0, cfg_ofs, cfg_write, cfg_size},
          {27'b0, a[1:0], w, sz});
      if (w) chk({tg, " cfg wdata"}, cfg_wdata, wd);
      k = $urandom % 3;
      repeat (k) begin
        @(negedge clk);
        chk("R9 cfg hold", {31'b0, cfg_valid}, 32'd1);
      end
      cfg_ready = 1'b1;
      @(negedge clk);
      cfg_ready = 1'b0; dn = $urandom; cfg_rsp_valid = 1'b1; cfg_rsp_rdata = dn;
      @(negedge clk);
      cfg_rsp_valid = 1'b0;
      exp = w ? 32'h0 : (dn & bmask(sz));
    end else begin
      chk({tg, " no forward"}, {30'b0, io_valid, cfg_valid}, 32'd0);
      if (cls == 1) exp = caddr_m;
      else if (cls == 3) exp = {24'b0, vec};
      exp = w ? 32'h0 : (exp & bmask(sz));
    end
    chk({tg, " rsp valid"}, {31'b0, rsp_valid}, 32'd1);
    got = rsp_rdata;
    chk({tg, " rdata"}, got, exp);
    if (!w) chk("R8 upper lanes zero", got & ~bmask(sz), 32'h0);
    k = $urandom % 3;
    repeat (k) begin
      @(negedge clk);
      chk("R9 rsp hold", {31'b0, rsp_valid}, 32'd1);
      chk("R9 rdata hold", rsp_rdata, got);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R9 back to idle", {30'b0, rsp_valid, req_ready}, 32'd1);
    if (cls == 1 && w)
      for (int b = 0; b <= int'(sz); b++) caddr_m[8*b +: 8] = wd[8*b +: 8];
    if (clr) err_m = 1'b0;
    if (cls == 4) err_m = 1'b1;
    chk("R7 err flag", {31'b0, err_flag}, {31'b0, err_m});
  endtask

  task automatic clear_err();
    @(negedge clk);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    err_m = 1'b0;
    chk("R7 clear", {31'b0, err_flag}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int pick;
    logic [23:0] a;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R10 reset idle", {27'b0, req_ready, rsp_valid, io_valid, cfg_valid, iack_strobe},
        32'h10);
    chk("R10 reset err", {31'b0, err_flag}, 32'd0);
    rst_n = 1'b1;

    run(24'hBFFFFF, 1'b0, 2'd3, 32'h0, 1'b0);          // R1 top of I/O space
    run(24'h000000, 1'b1, 2'd1, 32'hA5A5_1234, 1'b0);  // R1 write
    run(24'hC00000, 1'b0, 2'd3, 32'h0, 1'b0);          // R7 first non-I/O byte
    clear_err();
    run(24'hC00CF8, 1'b0, 2'd3, 32'h0, 1'b0);          // R2 reset value
    run(24'hC00CF8, 1'b1, 2'd3, 32'h8000_1234, 1'b0);  // R2 full write
    run(24'hC00CF8, 1'b1, 2'd0, 32'hFFFF_FF77, 1'b0);  // R2 byte write
    run(24'hC00CF8, 1'b0, 2'd3, 32'h0, 1'b0);          // R2 read back
    run(24'hE00CFF, 1'b0, 2'd0, 32'h0, 1'b0);          // R3 offset 3
    run(24'hE00CFD, 1'b1, 2'd1, 32'h0000_BEEF, 1'b0);  // R3 write
    run(24'hC00CF8, 1'b1, 2'd3, 32'h0000_0010, 1'b0);  // disable
    run(24'hE00CFC, 1'b0, 2'd3, 32'h0, 1'b0);          // R4 read ones
    run(24'hE00CFE, 1'b1, 2'd1, 32'h1234, 1'b0);       // R4 write dropped
    run(24'hC00CF9, 1'b0, 2'd0, 32'h0, 1'b0);          // R7 near miss
    run(24'hF00000, 1'b0, 2'd2, 32'h0, 1'b1);          // R5 with clear
    run(24'hF00000, 1'b1, 2'd0, 32'h55, 1'b0);         // R6
    run(24'hD12345, 1'b0, 2'd1, 32'h0, 1'b1);          // R7 set wins over clear
    clear_err();

    for (int i = 0; i < 400; i++) begin
      pick = $urandom % 6;
      case (pick)
        0: run(24'($urandom % 32'hC00000), 1'($urandom), 2'($urandom), $urandom,
               ($urandom % 8) == 0);
        1: run(24'hC00CF8, 1'($urandom), 2'($urandom), $urandom, 1'b0);
        2: run(24'hE00CFC + 24'($urandom % 4), 1'($urandom), 2'($urandom), $urandom,
               1'b0);
        3: run(24'hF00000, ($urandom % 4) == 0, 2'($urandom), $urandom,
               ($urandom % 8) == 0);
        4: begin
          a = 24'hC00000 + 24'($urandom % 32'h400000);
          while (classify(a, 1'b0) != 4) a = 24'hC00000 + 24'($urandom % 32'h400000);
          run(a, 1'($urandom), 2'($urandom), $urandom, ($urandom % 4) == 0);
        end
        default: clear_err();
      endcase
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule